// File: doc/BRIEF.md
# Comparator Edge Event Controller

This block is the digital side of an off-chip or on-die analog comparator. The comparator's raw output enters asynchronously. It can be inverted, and it then passes through a two-stage synchroniser into the bus clock domain. A selectable edge on the synchronised level sets a sticky edge flag. That flag, gated by a mask bit, forms the interrupt line.

A fault output for a motor-control or power-stage protection path is also produced. Depending on a mode bit, it follows either the sticky flag or the live synchronised level. A fault-enable bit can hold it low.

A small register interface provides the following:
- a single-cycle write strobe, a read strobe and a combinational read-data path;
- mode and analog settings, interrupt mask set and clear, and a status read that clears the flag;
- a software reset;
- a keyed write lock that guards the mode and analog settings.

The input-multiplexer selects, hysteresis and bias-current settings are only stored and driven out as static pins.

Top module: `cmp_edge_ctl`

## Requirements
- R1: Status read (offset 0x30) bit 1 shows the synchronised level. This is the raw input XOR the invert bit (mode bit 12), taken two clock edges earlier.
- R2: Mode bits [10:9] pick the edge. 0 means rising only, 1 means falling only, 2 means either, and 3 detects nothing. A qualifying edge sets the edge flag (status bit 0) one edge after the synchronised level shows it.
- R3: While the enable bit (mode bit 8) is 0, the edge flag is never set.
- R4: The edge flag stays set until a read strobe at offset 0x30. If a new edge arrives in the same cycle as that read, the flag stays set.
- R5: Writing bit 0 = 1 at offset 0x24 sets the mask bit, and writing bit 0 = 1 at offset 0x28 clears it. The mask reads back in bit 0 at 0x2C. `irq` is high exactly when both the flag and the mask are 1.
- R6: With fault enable (mode bit 14) at 0, `fault` is 0. With it at 1, mode bit 13 chooses the source: 0 selects the edge flag and 1 selects the synchronised level.
- R7: Writing bit 0 = 1 at offset 0x00 returns every register, flag and synchroniser stage to its reset value (all zero). Unmapped offsets read as 0.
- R8: A write to offset 0xE4 takes effect only if bits [31:8] equal `KEY`. Its bit 0 then becomes the lock bit, which reads back in bit 0. While the lock bit is 1, writes to 0x04 and 0x94 are dropped and set an error bit. That error bit reads in bit 0 of 0xE8 and clears on a read strobe there.
- R9: Offset 0x94 stores bit 0 as `cur_sel` and bits [2:1] as `hyst`, and reads back in the same positions.
- R10: Offset 0x04 stores mode bits [2:0], [6:4], 8, [10:9], 12, 13 and 14, and reads back with the other bits at 0. `minus_sel` = bits [2:0], `plus_sel` = bits [6:4] and `cmp_en` = bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe; triggers the read side effects |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| cmp_raw | input | 1 | Asynchronous comparator output |
| irq | output | 1 | Interrupt line |
| fault | output | 1 | Protection fault output |
| minus_sel | output | 3 | Negative-input select |
| plus_sel | output | 3 | Positive-input select |
| cmp_en | output | 1 | Comparator enable |
| cur_sel | output | 1 | Bias current select |
| hyst | output | 2 | Hysteresis select |

## Verification
The stimulus includes several deliberate collisions and boundary settings:
- **Flag read colliding with a new edge.** Random toggling of the comparator input is mixed with status reads so that an edge sometimes lands in the same cycle as the read. A design that lets the read win loses that event.
- **Reserved edge code 3.** A design that decodes it as "any" raises spurious flags.
- **Edges while disabled.** These check that the enable gate sits ahead of the flag.
- **Invert changes.** These check that the inversion sits before the synchroniser. If it is placed after the synchroniser, the level moves two cycles early.
- **Write lock.** The lock is exercised with a wrong key, with blocked mode writes and with a software reset. A design that checks the key loosely or commits blocked writes shows a changed mode readback.

// File: rtl/cmp_edge_ctl.sv
module cmp_edge_ctl #(
  parameter int          AW  = 8,
  parameter int          DW  = 32,
  parameter logic [23:0] KEY = 24'hC0FFEE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cmp_raw,
  output logic          irq,
  output logic          fault,
  output logic [2:0]    minus_sel,
  output logic [2:0]    plus_sel,
  output logic          cmp_en,
  output logic          cur_sel,
  output logic [1:0]    hyst
);
  localparam logic [AW-1:0] A_CTRL = AW'('h00);
  localparam logic [AW-1:0] A_MODE = AW'('h04);
  localparam logic [AW-1:0] A_MSET = AW'('h24);
  localparam logic [AW-1:0] A_MCLR = AW'('h28);
  localparam logic [AW-1:0] A_MASK = AW'('h2C);
  localparam logic [AW-1:0] A_STAT = AW'('h30);
  localparam logic [AW-1:0] A_ANLG = AW'('h94);
  localparam logic [AW-1:0] A_LOCK = AW'('hE4);
  localparam logic [AW-1:0] A_LERR = AW'('hE8);
  localparam logic [14:0]   MODE_BITS = 15'h7777;

  logic [14:0] mode_q;
  logic [2:0]  anlg_q;
  logic        mask_q, flag_q, lock_q, lerr_q;
  logic [1:0]  sync_q;
  logic        prev_q;

  wire soft_rst = wr_en && addr == A_CTRL && wdata[0];
  wire wr_prot  = wr_en && (addr == A_MODE || addr == A_ANLG);
  wire blocked  = wr_prot && lock_q;
  wire lvl      = sync_q[1];
  wire [1:0] etype = mode_q[10:9];

  logic edge_hit;
  always_comb begin
    case (etype)
      2'd0:    edge_hit = lvl & ~prev_q;
      2'd1:    edge_hit = ~lvl & prev_q;
      2'd2:    edge_hit = lvl ^ prev_q;
      default: edge_hit = 1'b0;
    endcase
    edge_hit = edge_hit & mode_q[8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; anlg_q <= '0; mask_q <= 1'b0; flag_q <= 1'b0;
      lock_q <= 1'b0; lerr_q <= 1'b0; sync_q <= '0; prev_q <= 1'b0;
    end else if (soft_rst) begin
      mode_q <= '0; anlg_q <= '0; mask_q <= 1'b0; flag_q <= 1'b0;
      lock_q <= 1'b0; lerr_q <= 1'b0; sync_q <= '0; prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], cmp_raw ^ mode_q[12]};
      prev_q <= lvl;
      if (edge_hit)                        flag_q <= 1'b1;
      else if (rd_en && addr == A_STAT)    flag_q <= 1'b0;
      if (blocked)                         lerr_q <= 1'b1;
      else if (rd_en && addr == A_LERR)    lerr_q <= 1'b0;
      if (wr_en && addr == A_MSET && wdata[0]) mask_q <= 1'b1;
      if (wr_en && addr == A_MCLR && wdata[0]) mask_q <= 1'b0;
      if (wr_prot && !lock_q && addr == A_MODE) mode_q <= wdata[14:0] & MODE_BITS;
      if (wr_prot && !lock_q && addr == A_ANLG) anlg_q <= wdata[2:0];
      if (wr_en && addr == A_LOCK && wdata[31:8] == KEY) lock_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE:  rdata[14:0] = mode_q;
      A_MASK:  rdata[0]    = mask_q;
      A_STAT:  rdata[1:0]  = {lvl, flag_q};
      A_ANLG:  rdata[2:0]  = anlg_q;
      A_LOCK:  rdata[0]    = lock_q;
      A_LERR:  rdata[0]    = lerr_q;
      default: rdata = '0;
    endcase
  end

  assign irq       = flag_q & mask_q;
  assign fault     = mode_q[14] & (mode_q[13] ? lvl : flag_q);
  assign minus_sel = mode_q[2:0];
  assign plus_sel  = mode_q[6:4];
  assign cmp_en    = mode_q[8];
  assign cur_sel   = anlg_q[0];
  assign hyst      = anlg_q[2:1];

  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(rd_en && addr == A_STAT) && !soft_rst |=> flag_q);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == A_STAT && !edge_hit && !soft_rst |=> !flag_q);
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[8] |=> !$rose(flag_q));
  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && wr_en && addr == A_MODE |=> $stable(mode_q) && lerr_q);
  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> mode_q == '0 && !mask_q && !flag_q && !lock_q && !irq);
endmodule

// File: tb/cmp_edge_ctl_tb_top.sv
module cmp_edge_ctl_tb_top;
  localparam logic [23:0] KEY = 24'hC0FFEE;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cmp_raw = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0, rdata;
  logic irq, fault, cmp_en, cur_sel;
  logic [2:0] minus_sel, plus_sel;
  logic [1:0] hyst;
  int total = 0, bad = 0, cycles = 0;
  string tag = "R7";

  cmp_edge_ctl #(.KEY(KEY)) dut_i (.*);

  always #5 clk = ~clk;

  // behavioural reference
  logic [14:0] m_mode; logic [2:0] m_anlg;
  logic m_mask, m_flag, m_lock, m_lerr;
  logic q[$] = '{1'b0, 1'b0, 1'b0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = '0; m_anlg = '0; m_mask = 0; m_flag = 0; m_lock = 0; m_lerr = 0;
      q = '{1'b0, 1'b0, 1'b0};
    end else if (wr_en && addr == 8'h00 && wdata[0]) begin
      m_mode = '0; m_anlg = '0; m_mask = 0; m_flag = 0; m_lock = 0; m_lerr = 0;
      q = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit cur, prv, hit, d;
      cur = q[1]; prv = q[2];
      case (m_mode[10:9])
        0: hit = cur && !prv;
        1: hit = !cur && prv;
        2: hit = cur != prv;
        default: hit = 0;
      endcase
      hit = hit && m_mode[8];
      d = cmp_raw ^ m_mode[12];
      if (hit) m_flag = 1; else if (rd_en && addr == 8'h30) m_flag = 0;
      if (wr_en && (addr == 8'h04 || addr == 8'h94) && m_lock) m_lerr = 1;
      else if (rd_en && addr == 8'hE8) m_lerr = 0;
      if (wr_en && addr == 8'h24 && wdata[0]) m_mask = 1;
      if (wr_en && addr == 8'h28 && wdata[0]) m_mask = 0;
      if (wr_en && !m_lock && addr == 8'h04) m_mode = wdata[14:0] & 15'h7777;
      if (wr_en && !m_lock && addr == 8'h94) m_anlg = wdata[2:0];
      if (wr_en && addr == 8'hE4 && wdata[31:8] == KEY) m_lock = wdata[0];
      q.push_front(d); void'(q.pop_back());
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h04: return {17'd0, m_mode};
      8'h2C: return {31'd0, m_mask};
      8'h30: return {30'd0, q[1], m_flag};
      8'h94: return {29'd0, m_anlg};
      8'hE4: return {31'd0, m_lock};
      8'hE8: return {31'd0, m_lerr};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    #2;
    cycles++;
    chk(tag, rdata, exp_rd(addr));
    chk("R5", irq, m_flag & m_mask);
    chk("R6", fault, m_mode[14] ? (m_mode[13] ? q[1] : m_flag) : 1'b0);
    chk("R10", {minus_sel, plus_sel, cmp_en}, {m_mode[2:0], m_mode[6:4], m_mode[8]});
    chk("R9", {hyst, cur_sel}, m_anlg);
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [7:0] a);
    rd_en = 1; addr = a; @(negedge clk); rd_en = 0;
  endtask
  task automatic idle(int n, logic [7:0] a);
    addr = a; repeat (n) @(negedge clk);
  endtask
  task automatic pulse(logic [7:0] a);
    cmp_raw = ~cmp_raw; idle(4, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R7"; idle(2, 8'h04);
    tag = "R2"; wr(8'h04, 32'h100);
    repeat (4) pulse(8'h30); rd(8'h30);
    wr(8'h04, 32'h300); repeat (4) pulse(8'h30);
    tag = "R4"; rd(8'h30); idle(2, 8'h30);
    tag = "R2"; wr(8'h04, 32'h500); repeat (3) pulse(8'h30); rd(8'h30);
    wr(8'h04, 32'h700); repeat (3) pulse(8'h30);
    tag = "R1"; wr(8'h04, 32'h1100); idle(4, 8'h30); pulse(8'h30); wr(8'h04, 32'h100); idle(3, 8'h30);
    tag = "R3"; rd(8'h30); wr(8'h04, 32'h400); repeat (4) pulse(8'h30);
    tag = "R5"; wr(8'h04, 32'h500); wr(8'h24, 1); idle(1, 8'h2C);
    pulse(8'h30); rd(8'h30); pulse(8'h2C); wr(8'h28, 1); idle(2, 8'h2C);
    tag = "R6"; wr(8'h04, 32'h4500); pulse(8'h30); rd(8'h30);
    wr(8'h04, 32'h6500); repeat (3) pulse(8'h30); wr(8'h04, 32'h2500); pulse(8'h30);
    tag = "R4";
    for (int i = 0; i < 60; i++) begin
      cmp_raw = 1'($urandom);
      if (i % 3 == 0) rd(8'h30); else idle(1, 8'h30);
    end
    tag = "R9"; wr(8'h94, 32'h5); idle(1, 8'h94); wr(8'h94, 32'hFFFF_FFFA); idle(1, 8'h94);
    tag = "R10"; wr(8'h04, 32'hFFFF_FF53); idle(1, 8'h04); wr(8'h04, 32'h0000_0135); idle(1, 8'h04);
    tag = "R8"; wr(8'hE4, 32'hC0FFEF01); idle(1, 8'hE4);
    wr(8'hE4, {KEY, 8'h01}); idle(1, 8'hE4);
    wr(8'h04, 32'h7777); idle(1, 8'h04); wr(8'h94, 32'h2); idle(1, 8'hE8);
    rd(8'hE8); idle(1, 8'hE8);
    wr(8'hE4, {KEY, 8'h00}); wr(8'h04, 32'h1234); idle(1, 8'h04);
    tag = "R7"; wr(8'hE4, {KEY, 8'h01}); wr(8'h24, 1); wr(8'h00, 1);
    idle(1, 8'h04); idle(1, 8'hE4); idle(1, 8'h2C); idle(1, 8'h10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule